// File: doc/BRIEF.md
# Quadword Memory-to-Memory DMA Channel

This block is one memory-to-memory DMA channel that moves whole 16-byte quadwords. It also holds a DMA interrupt register that other channels share. Software loads a source address, a target address and a quadword count through a small register port. It then writes the control register with the go bit set. The engine reads each 32-bit word from the source and writes it to the target plus a fixed destination base. Words move in ascending address order, four words to a quadword, and each word is read before it is written.

When the last word has been written, the channel clears its go bit, zeroes the count and raises its own bit in the shared status half of the interrupt register. A single interrupt output is high while any status bit is paired with a set mask bit. Other DMA sources raise their status bits through a 16-bit event input. Software clears status bits by writing ones to them. Clearing software writes status bits to zero. Mask writes go to a separate register, so clearing status never touches the mask.

Top module: `qdma_channel`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and no memory request is raised.
- R2: Registers sit on a 16-byte stride and the low four address bits are ignored. The offsets are 0x00 control (go bit at bit 8), 0x10 quadword count, 0x20 source address, 0x30 target address, 0x40 interrupt status/mask, and 0x50 mask write. Unmapped offsets read zero.
- R3: A write to control with bit 8 set while idle, with count N>0, copies N×16 bytes. The copy reads word source+4k and then writes it to DST_BASE+target+4k, for k from 0 up to 4N-1. Words outside that target range stay unchanged.
- R4: At completion the count reads zero, control bit 8 reads zero and status bit 2 is set.
- R5: A start with a count of zero makes no memory access. It completes at once, setting status bit 2.
- R6: Once raised, a memory request keeps its address, direction and write data stable until it is acknowledged. Each acknowledge moves exactly one 32-bit word.
- R7: A control write with bit 8 clear during a transfer stops it after the beat in progress. No further requests follow. The count keeps the quadwords not fully written, and status bit 2 stays clear.
- R8: During a transfer, writes to the count register and further start writes have no effect.
- R9: The status register at 0x40 reads status in [15:0] and mask in [31:16]. Event input bits set status bits, and a write clears each status bit written as 1. The mask half is unchanged by that write, and a set wins over a clear in the same cycle.
- R10: A write to 0x50 loads the 16 mask bits from data [15:0].
- R11: The interrupt output is high exactly when some status bit and its mask bit are both set. It drops once their AND is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | REG_AW | Register byte address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| eventIn | input | 16 | One-cycle set pulses for the shared status bits |
| irq | output | 1 | Combined DMA interrupt |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | AW | Word address of the beat |
| memWdata | output | 32 | Write data of a write beat |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Beat acknowledge |

## Verification
The checker watches several rules on every cycle. It checks that a pending memory request holds its address and direction, and that no request is raised while the go bit reads clear. It checks that completion leaves a zero count, a cleared go bit and status bit 2 set. It also checks that clearing status leaves the mask unchanged. The bench scenarios are needed for the rest: the copied data, the ordering and bounds of the target region, and the point at which a stopped transfer halts. They also cover the ignored writes while busy and the interrupt level under different mask and status patterns, across sweeps of count and memory latency.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_READ  = 2'd1,
    ENG_WRITE = 2'd2
  } engState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // capture working pointers, raise go
    logic capture;  // latch read data
    logic advance;  // step pointers after a write beat
    logic finish;   // normal completion
    logic halt;     // stopped by software
  } engStrobe_t;

  localparam int SLOT_CTRL  = 0;
  localparam int SLOT_COUNT = 1;
  localparam int SLOT_SRC   = 2;
  localparam int SLOT_TGT   = 3;
  localparam int SLOT_STAT  = 4;
  localparam int SLOT_MASK  = 5;

  localparam int GO_BIT     = 8;
  localparam int CHAN_BIT   = 2;
  localparam int NUM_STAT   = 16;
  localparam int WORD_BYTES = 4;
  localparam int BEATS_QW   = 4;

endpackage

// File: rtl/qdma_ctrl.sv
module qdma_ctrl
  import qdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       countZero,
  input  logic       lastWord,
  input  logic       memAck,
  output logic       memReq,
  output logic       memWe,
  output engStrobe_t strb
);

  engState_t state, stateNext;
  logic stopPend;
  logic stopNow;

  assign stopNow = stopPend | stopReq;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ENG_IDLE: begin
        if (startReq) begin
          if (countZero) begin
            strb.finish = 1'b1;
          end else begin
            strb.load = 1'b1;
            stateNext = ENG_READ;
          end
        end
      end
      ENG_READ: begin
        if (memAck) begin
          if (stopNow) begin
            strb.halt = 1'b1;
            stateNext = ENG_IDLE;
          end else begin
            strb.capture = 1'b1;
            stateNext    = ENG_WRITE;
          end
        end
      end
      ENG_WRITE: begin
        if (memAck) begin
          strb.advance = 1'b1;
          if (lastWord) begin
            strb.finish = 1'b1;
            stateNext   = ENG_IDLE;
          end else if (stopNow) begin
            strb.halt = 1'b1;
            stateNext = ENG_IDLE;
          end else begin
            stateNext = ENG_READ;
          end
        end
      end
      default: stateNext = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ENG_IDLE;
      stopPend <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ENG_IDLE || strb.halt || strb.finish) begin
        stopPend <= 1'b0;
      end else if (stopReq) begin
        stopPend <= 1'b1;
      end
    end
  end

  assign memReq = (state != ENG_IDLE);
  assign memWe  = (state == ENG_WRITE);

endmodule

// File: rtl/qdma_dpath.sv
module qdma_dpath
  import qdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int QW_W = 16,
  parameter int REG_AW = 8,
  parameter logic [AW-1:0] DST_BASE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic                regWe,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_STAT-1:0] eventIn,
  input  engStrobe_t          strb,
  input  logic                memWe,
  input  logic [31:0]         memRdata,
  output logic [AW-1:0]       memAddr,
  output logic [31:0]         memWdata,
  output logic                startReq,
  output logic                stopReq,
  output logic                countZero,
  output logic                lastWord,
  output logic                goBit,
  output logic                irq,
  output logic [NUM_STAT-1:0] statBits,
  output logic [NUM_STAT-1:0] maskBits
);

  localparam int IDX_W  = REG_AW - 4;
  localparam int BEAT_W = $clog2(BEATS_QW);

  logic [IDX_W-1:0]  regIdx;
  logic              unusedNibble;
  logic              wrCtrl, wrCount, wrSrc, wrTgt, wrStat, wrMask;
  logic [QW_W-1:0]   qwcReg;
  logic [AW-1:0]     srcReg, tgtReg;
  logic [AW-1:0]     workSrc, workDst;
  logic [BEAT_W-1:0] beatIdx;
  logic [31:0]       dataBuf;
  logic [NUM_STAT-1:0] statSet, statClr;

  assign regIdx       = regAddr[REG_AW-1:4];
  assign unusedNibble = ^regAddr[3:0];

  assign wrCtrl  = regWe && (regIdx == IDX_W'(SLOT_CTRL));
  assign wrCount = regWe && (regIdx == IDX_W'(SLOT_COUNT));
  assign wrSrc   = regWe && (regIdx == IDX_W'(SLOT_SRC));
  assign wrTgt   = regWe && (regIdx == IDX_W'(SLOT_TGT));
  assign wrStat  = regWe && (regIdx == IDX_W'(SLOT_STAT));
  assign wrMask  = regWe && (regIdx == IDX_W'(SLOT_MASK));

  assign startReq = wrCtrl &&  regWdata[GO_BIT] && !goBit;
  assign stopReq  = wrCtrl && !regWdata[GO_BIT] &&  goBit;

  assign countZero = (qwcReg == '0);
  assign lastWord  = (qwcReg == QW_W'(1)) && (beatIdx == BEAT_W'(BEATS_QW - 1));

  // programmed registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg <= '0;
      tgtReg <= '0;
    end else begin
      if (wrSrc) srcReg <= AW'(regWdata);
      if (wrTgt) tgtReg <= AW'(regWdata);
    end
  end

  // count and go bit: the engine owns the count while busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qwcReg <= '0;
      goBit  <= 1'b0;
    end else begin
      if (strb.finish) begin
        qwcReg <= '0;
      end else if (strb.advance && beatIdx == BEAT_W'(BEATS_QW - 1)) begin
        qwcReg <= qwcReg - QW_W'(1);
      end else if (wrCount && !goBit) begin
        qwcReg <= regWdata[QW_W-1:0];
      end
      if (strb.finish || strb.halt) begin
        goBit <= 1'b0;
      end else if (strb.load) begin
        goBit <= 1'b1;
      end
    end
  end

  // working pointers and the word buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      workSrc <= '0;
      workDst <= '0;
      beatIdx <= '0;
      dataBuf <= '0;
    end else begin
      if (strb.load) begin
        workSrc <= srcReg;
        workDst <= tgtReg + DST_BASE;
        beatIdx <= '0;
      end else if (strb.advance) begin
        workSrc <= workSrc + AW'(WORD_BYTES);
        workDst <= workDst + AW'(WORD_BYTES);
        beatIdx <= beatIdx + BEAT_W'(1);
      end
      if (strb.capture) dataBuf <= memRdata;
    end
  end

  assign memAddr  = memWe ? workDst : workSrc;
  assign memWdata = dataBuf;

  // shared interrupt status and mask
  always_comb begin
    statSet = eventIn;
    statSet[CHAN_BIT] = eventIn[CHAN_BIT] | strb.finish;
    statClr = wrStat ? regWdata[NUM_STAT-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statBits <= '0;
      maskBits <= '0;
    end else begin
      statBits <= (statBits & ~statClr) | statSet;
      if (wrMask) maskBits <= regWdata[NUM_STAT-1:0];
    end
  end

  assign irq = |(statBits & maskBits);

  // register read mux
  always_comb begin
    regRdata = '0;
    unique case (regIdx)
      IDX_W'(SLOT_CTRL):  regRdata[GO_BIT] = goBit;
      IDX_W'(SLOT_COUNT): regRdata = 32'(qwcReg);
      IDX_W'(SLOT_SRC):   regRdata = 32'(srcReg);
      IDX_W'(SLOT_TGT):   regRdata = 32'(tgtReg);
      IDX_W'(SLOT_STAT):  regRdata = {maskBits, statBits};
      IDX_W'(SLOT_MASK):  regRdata = 32'(maskBits);
      default:            regRdata = '0;
    endcase
  end

endmodule

// File: rtl/qdma_channel.sv
module qdma_channel
  import qdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int QW_W = 16,
  parameter int REG_AW = 8,
  parameter logic [AW-1:0] DST_BASE = AW'(32'h0001_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [15:0]       eventIn,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck
);

  engStrobe_t strb;
  logic startReq, stopReq, countZero, lastWord, goBit;
  logic [NUM_STAT-1:0] statBits, maskBits;

  qdma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .stopReq   (stopReq),
    .countZero (countZero),
    .lastWord  (lastWord),
    .memAck    (memAck),
    .memReq    (memReq),
    .memWe     (memWe),
    .strb      (strb)
  );

  qdma_dpath #(
    .AW       (AW),
    .QW_W     (QW_W),
    .REG_AW   (REG_AW),
    .DST_BASE (DST_BASE)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWe     (regWe),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .eventIn   (eventIn),
    .strb      (strb),
    .memWe     (memWe),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .startReq  (startReq),
    .stopReq   (stopReq),
    .countZero (countZero),
    .lastWord  (lastWord),
    .goBit     (goBit),
    .irq       (irq),
    .statBits  (statBits),
    .maskBits  (maskBits)
  );

endmodule

// File: rtl/qdma_checker.sv
module qdma_checker
  import qdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int REG_AW = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                memReq,
  input logic                memAck,
  input logic                memWe,
  input logic [AW-1:0]       memAddr,
  input logic                goBit,
  input logic                countZero,
  input engStrobe_t          strb,
  input logic [NUM_STAT-1:0] statBits,
  input logic [NUM_STAT-1:0] maskBits,
  input logic                regWe,
  input logic [REG_AW-1:0]   regAddr
);

  logic statWrite;
  assign statWrite = regWe && (regAddr[REG_AW-1:4] == (REG_AW-4)'(SLOT_STAT));

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !goBit |-> !memReq); // R7

  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (countZero && !goBit)); // R4

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> statBits[CHAN_BIT]); // R4

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    statWrite |=> $stable(maskBits)); // R9

endmodule

bind qdma_channel qdma_checker #(.AW(AW), .REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memAck    (memAck),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .goBit     (goBit),
  .countZero (countZero),
  .strb      (strb),
  .statBits  (statBits),
  .maskBits  (maskBits),
  .regWe     (regWe),
  .regAddr   (regAddr)
);

// File: tb/tb_qdma_channel.sv
module tb_qdma_channel;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_0800;
  localparam logic [7:0] A_CTRL = 8'h00, A_COUNT = 8'h10, A_SRC = 8'h20,
                         A_TGT = 8'h30, A_STAT = 8'h40, A_MASK = 8'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [15:0] eventIn = '0;
  logic        irq, memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  int checks = 0;
  int failures = 0;
  int memLat = 0;
  int waitCnt = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  bit doneFlag = 0;
  logic [31:0] mem [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  qdma_channel #(.DST_BASE(BASE)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .eventIn(eventIn), .irq(irq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  // memory model with programmable wait states
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      if (waitCnt < memLat) begin
        waitCnt = waitCnt + 1;
      end else begin
        waitCnt = 0;
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr[11:2]] = memWdata;
          wrCnt = wrCnt + 1;
        end else begin
          memRdata <= mem[memAddr[11:2]];
          rdCnt = rdCnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regRead(A_CTRL, v);
      if (v[8] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] pat(input int seed, input int k);
    return 32'hA500_0000 ^ (32'(seed) << 12) ^ (32'(k) * 32'h0101_0107);
  endfunction

  task automatic runCopy(input int src, input int tgt, input int qw, input int lat, input int seed);
    logic [31:0] v;
    int nw;
    int dIdx;
    bit dataOk;
    nw = qw * 4;
    memLat = lat;
    for (int k = 0; k < nw; k++) mem[(src >> 2) + k] = pat(seed, k);
    for (int k = 0; k <= nw; k++) mem[((BASE + tgt) >> 2) + k] = 32'hDEAD_0000 | 32'(k);
    regWrite(A_STAT, 32'h0000_FFFF);
    regWrite(A_COUNT, 32'(qw));
    regWrite(A_SRC, 32'(src));
    regWrite(A_TGT, 32'(tgt));
    rdCnt = 0; wrCnt = 0;
    regWrite(A_CTRL, 32'h0000_0100);
    waitIdle();
    dIdx = int'((BASE + 32'(tgt)) >> 2);
    dataOk = 1;
    for (int k = 0; k < nw; k++) begin
      if (mem[dIdx + k] !== pat(seed, k)) begin
        dataOk = 0;
        check(0, "R3 copied word", mem[dIdx + k], pat(seed, k));
      end
    end
    check(dataOk, "R3 copy block", 32'(qw), 32'(qw));
    check(mem[dIdx + nw] === (32'hDEAD_0000 | 32'(nw)), "R3 guard word", mem[dIdx + nw], 32'hDEAD_0000 | 32'(nw));
    check(wrCnt == nw && rdCnt == nw, (qw == 0) ? "R5 beat count" : "R6 beat count", 32'(wrCnt), 32'(nw));
    regRead(A_COUNT, v);
    check(v == 0, "R4 count zero", v, 0);
    regRead(A_CTRL, v);
    check(v == 0, "R4 go clear", v, 0);
    regRead(A_STAT, v);
    check(v[2] == 1'b1, (qw == 0) ? "R5 status bit2" : "R4 status bit2", v, 32'h4);
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (doneFlag) break;
    end
    if (!doneFlag) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    int w;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (v[i]) v[i] = 1'b0;
    for (int a = 0; a < 6; a++) begin
      regRead(8'(a * 16), v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(irq == 1'b0 && memReq == 1'b0, "R1 reset outputs", {30'd0, irq, memReq}, 0);

    // R2 stride decoding and low nibble ignored
    regWrite(8'h24, 32'h0000_0340);
    regRead(8'h2C, v);
    check(v == 32'h340, "R2 source readback", v, 32'h340);
    regWrite(8'h3F, 32'h0000_0120);
    regRead(A_TGT, v);
    check(v == 32'h120, "R2 target readback", v, 32'h120);
    regRead(8'h70, v);
    check(v == 0, "R2 unmapped reads zero", v, 0);

    // R3 R4 R5 R6 sweep over count and latency
    for (int qw = 0; qw <= 4; qw++) begin
      for (int lat = 0; lat <= 2; lat++) begin
        runCopy(32'h40 * qw + 16 * lat, 32'h100 * lat + 32'h10 * qw, qw, lat, qw * 3 + lat);
      end
    end

    // R7 stop mid transfer
    memLat = 1;
    regWrite(A_STAT, 32'h0000_FFFF);
    regWrite(A_COUNT, 32'd8);
    regWrite(A_SRC, 32'h0);
    regWrite(A_TGT, 32'h400);
    rdCnt = 0; wrCnt = 0;
    regWrite(A_CTRL, 32'h100);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (wrCnt >= 5) break;
    end
    regWrite(A_CTRL, 32'h0);
    waitIdle();
    regRead(A_COUNT, v);
    c = int'(v);
    check(c > 0 && c < 8, "R7 remaining count", v, 32'd8);
    w = wrCnt;
    check(w >= (8 - c) * 4 && w <= (8 - c) * 4 + 3, "R7 words vs count", 32'(w), 32'((8 - c) * 4));
    regRead(A_STAT, v);
    check(v[2] == 1'b0, "R7 no status", v, 0);
    repeat (30) @(negedge clk);
    check(wrCnt == w && memReq == 1'b0, "R7 bus quiet", 32'(wrCnt), 32'(w));

    // R8 writes while busy ignored
    memLat = 2;
    for (int k = 0; k < 12; k++) mem[(32'h200 >> 2) + k] = pat(77, k);
    regWrite(A_STAT, 32'h0000_FFFF);
    regWrite(A_COUNT, 32'd3);
    regWrite(A_SRC, 32'h200);
    regWrite(A_TGT, 32'h500);
    rdCnt = 0; wrCnt = 0;
    regWrite(A_CTRL, 32'h100);
    regWrite(A_COUNT, 32'd7);
    regWrite(A_CTRL, 32'h100);
    regRead(A_COUNT, v);
    check(v <= 3, "R8 count write ignored", v, 32'd3);
    waitIdle();
    check(wrCnt == 12, "R8 words moved", 32'(wrCnt), 32'd12);
    check(mem[((BASE + 32'h500) >> 2) + 11] == pat(77, 11), "R8 last word", mem[((BASE + 32'h500) >> 2) + 11], pat(77, 11));
    regRead(A_COUNT, v);
    check(v == 0, "R8 count after", v, 0);

    // R9 R10 R11 status and mask
    regWrite(A_STAT, 32'h0000_FFFF);
    regWrite(A_MASK, 32'h0);
    @(negedge clk);
    eventIn = 16'h0020;
    @(negedge clk);
    eventIn = 16'h0;
    regRead(A_STAT, v);
    check(v == 32'h0000_0020, "R9 event sets status", v, 32'h20);
    check(irq == 1'b0, "R11 masked off", {31'd0, irq}, 0);
    regWrite(A_MASK, 32'h0000_0024);
    regRead(A_MASK, v);
    check(v == 32'h24, "R10 mask load", v, 32'h24);
    check(irq == 1'b1, "R11 irq on", {31'd0, irq}, 1);
    regWrite(A_STAT, 32'hFFFF_0000);
    regRead(A_STAT, v);
    check(v == 32'h0024_0020, "R9 upper write no effect", v, 32'h0024_0020);
    regWrite(A_STAT, 32'h0000_0020);
    regRead(A_STAT, v);
    check(v == 32'h0024_0000, "R9 clear keeps mask", v, 32'h0024_0000);
    check(irq == 1'b0, "R11 irq drops", {31'd0, irq}, 0);
    @(negedge clk);
    regAddr = A_STAT; regWdata = 32'h0000_0080; regWe = 1'b1; eventIn = 16'h0080;
    @(negedge clk);
    regWe = 1'b0; eventIn = 16'h0;
    regRead(A_STAT, v);
    check(v[7] == 1'b1, "R9 set wins", v, 32'h80);
    regWrite(A_STAT, 32'h0000_FFFF);
    runCopy(32'h40, 32'h40, 1, 0, 99);
    check(irq == 1'b1, "R11 channel irq", {31'd0, irq}, 1);
    regWrite(A_STAT, 32'h0000_0004);
    check(irq == 1'b0, "R11 channel irq cleared", {31'd0, irq}, 0);

    doneFlag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule